// File: doc/BRIEF.md
# Threshold-Ready Transmit Buffer Bank

This block holds a small transmit FIFO for each of several antenna-carrier sample streams. A producer pushes samples into each channel through a valid/ready sink. A framing stage on the other side drains each buffer through a per-channel read strobe. Each channel raises its ready output while its fill level is below one threshold value that all channels share. Setting the threshold lets the producer be throttled well before a buffer fills.

A parameter selects the meaning of ready. With latency zero, a sample is taken in any cycle where valid and ready are both high. With latency one, ready announces that the next cycle is a transfer cycle. Each channel exports a three-bit status word: sticky overflow, sticky underflow and the channel enable. A small write-only register port sets the threshold and the enables, and clears the sticky bits. Everything runs on one clock.

Top module: `txbuf_bank`

## Requirements
- R1: A channel's `s_ready` bit is high exactly when that channel is enabled and its fill level is below the threshold. One threshold serves all channels, but each channel drives its own ready bit. The threshold is set by a register write with `cfg_addr`=0, taking `cfg_wdata[THR_W-1:0]`.
- R2: With `READY_LAT`=0, a sample is stored in any clock cycle where `s_valid` and `s_ready` of that channel are both high.
- R3: With `READY_LAT`=1, a sample is stored in a cycle only if `s_valid` is high in that cycle and `s_ready` was high in the previous cycle. Valid presented in the first ready-high cycle is not stored.
- R4: A high `rd_en` bit on an enabled, non-empty channel removes the oldest sample. The sample appears on that channel's 32-bit slice of `rd_data` one clock later, and samples leave in arrival order. A read and a write may occur in the same cycle.
- R5: An attempted transfer into a full buffer is discarded and sets status bit 2 (overflow) of that channel. This is possible when the threshold exceeds the depth.
- R6: A read of an enabled, empty buffer returns zero on `rd_data` one clock later, leaves the contents unchanged and sets status bit 1 (underflow).
- R7: Overflow and underflow stay set until a write with `cfg_addr`=2 clears them. In that write, `cfg_wdata` bit i clears overflow of channel i, and bit NUM_CH+i clears underflow of channel i.
- R8: Status bit 0 is the channel enable, which is bit i of a write with `cfg_addr`=1. A disabled channel holds ready low, empties its buffer and ignores samples and reads: a read returns zero and sets no flag.
- R9: After reset, the threshold is zero, all channels are disabled and empty, every ready bit is low and every status word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 threshold, 1 enables, 2 clear flags |
| cfg_wdata | input | CFG_W (32) | Register write data |
| s_valid | input | NUM_CH (4) | Per-channel sample valid |
| s_data | input | NUM_CH*DATA_W (128) | Per-channel samples, channel i in bits [32i+31:32i] |
| s_ready | output | NUM_CH (4) | Per-channel ready |
| rd_en | input | NUM_CH (4) | Per-channel drain strobe |
| rd_data | output | NUM_CH*DATA_W (128) | Per-channel drained sample, one clock after the strobe |
| status | output | NUM_CH*3 (12) | Per-channel {overflow, underflow, enable}, channel i in bits [3i+2:3i] |

## Verification
Overflow is the hardest state to reach. With the threshold at or below the depth, ready never lets a full buffer see a transfer, so the bench raises the threshold to its maximum and pushes one sample more than the depth. It then drains the channel to show that the extra sample was dropped. For the latency-one variant, a second instance shares the stimulus. The bench offers a sample in the very first ready-high cycle after the channel is enabled, and a read-back confirms that only the following cycle's sample was stored.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  typedef enum logic [1:0] {
    REG_THR = 2'd0,
    REG_EN  = 2'd1,
    REG_CLR = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic ovf;
    logic udf;
    logic en;
  } ch_status_t;

  localparam int unsigned STATUS_W = 3;
endpackage

// File: rtl/txbuf_cfg.sv
module txbuf_cfg
  import txbuf_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned THR_W  = 5,
  parameter int unsigned CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [THR_W-1:0]  thr_q,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] clr_ovf,
  output logic [NUM_CH-1:0] clr_udf
);
  logic wr_thr, wr_en, wr_clr;
  logic unused_wdata;

  assign wr_thr = cfg_wr && (cfg_addr == REG_THR);
  assign wr_en  = cfg_wr && (cfg_addr == REG_EN);
  assign wr_clr = cfg_wr && (cfg_addr == REG_CLR);
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= '0;
      en_q  <= '0;
    end else begin
      if (wr_thr) thr_q <= cfg_wdata[THR_W-1:0];
      if (wr_en)  en_q  <= cfg_wdata[NUM_CH-1:0];
    end
  end

  assign clr_ovf = wr_clr ? cfg_wdata[NUM_CH-1:0] : '0;
  assign clr_udf = wr_clr ? cfg_wdata[2*NUM_CH-1:NUM_CH] : '0;

  AST_THR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_thr |=> $stable(thr_q)); // R1
endmodule

// File: rtl/txbuf_chan.sv
module txbuf_chan
  import txbuf_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned THR_W     = 5,
  parameter int unsigned READY_LAT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [THR_W-1:0]  thr_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              clr_ovf_i,
  input  logic              clr_udf_i,
  output ch_status_t        status_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  fill_q;
  logic              zero_q, ovf_q, udf_q;
  logic [CMP_W-1:0]  fill_x, thr_x;
  logic              ready_now, ready_cycle;
  logic              full, empty, wr_try, wr_do, rd_try, rd_do;

  assign fill_x    = CMP_W'(fill_q);
  assign thr_x     = CMP_W'(thr_i);
  assign ready_now = en_i && (fill_x < thr_x);
  assign s_ready_o = ready_now;

  generate
    if (READY_LAT == 0) begin : g_lat0
      assign ready_cycle = ready_now;
    end else begin : g_lat1
      logic rdy_d1_q;
      always_ff @(posedge clk) begin
        if (rst) rdy_d1_q <= 1'b0;
        else     rdy_d1_q <= ready_now;
      end
      assign ready_cycle = rdy_d1_q && en_i;
    end
  endgenerate

  assign full   = (fill_q == CNT_W'(DEPTH));
  assign empty  = (fill_q == '0);
  assign wr_try = s_valid_i && ready_cycle;
  assign wr_do  = wr_try && !full;
  assign rd_try = rd_en_i && en_i;
  assign rd_do  = rd_try && !empty;

  always_ff @(posedge clk) begin
    if (wr_do) mem[wptr_q] <= s_data_i;
    if (rd_do) mem_q <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      fill_q <= '0;
    end else begin
      if (wr_do) wptr_q <= (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (rd_do) rptr_q <= (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({wr_do, rd_do})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_q <= 1'b1;
      ovf_q  <= 1'b0;
      udf_q  <= 1'b0;
    end else begin
      if (rd_en_i) zero_q <= !rd_do;
      if (wr_try && full)  ovf_q <= 1'b1;
      else if (clr_ovf_i)  ovf_q <= 1'b0;
      if (rd_try && empty) udf_q <= 1'b1;
      else if (clr_udf_i)  udf_q <= 1'b0;
    end
  end

  assign rd_data_o = zero_q ? '0 : mem_q;
  assign status_o  = '{ovf: ovf_q, udf: udf_q, en: en_i};

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill_q <= CNT_W'(DEPTH)); // R5
  AST_DISABLED_FLUSH: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (fill_q == '0)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_q && !clr_ovf_i |=> ovf_q); // R7
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst)
    udf_q && !clr_udf_i |=> udf_q); // R7
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    rd_en_i && en_i && empty |=> udf_q && (rd_data_o == '0)); // R6
endmodule

// File: rtl/txbuf_bank.sv
module txbuf_bank
  import txbuf_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned THR_W     = 5,
  parameter int unsigned CFG_W     = 32,
  parameter int unsigned READY_LAT = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_wr,
  input  logic [1:0]                 cfg_addr,
  input  logic [CFG_W-1:0]           cfg_wdata,
  input  logic [NUM_CH-1:0]          s_valid,
  input  logic [NUM_CH*DATA_W-1:0]   s_data,
  output logic [NUM_CH-1:0]          s_ready,
  input  logic [NUM_CH-1:0]          rd_en,
  output logic [NUM_CH*DATA_W-1:0]   rd_data,
  output logic [NUM_CH*STATUS_W-1:0] status
);
  logic [THR_W-1:0]  thr_q;
  logic [NUM_CH-1:0] en_q, clr_ovf, clr_udf;

  txbuf_cfg #(.NUM_CH(NUM_CH), .THR_W(THR_W), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .thr_q(thr_q), .en_q(en_q),
    .clr_ovf(clr_ovf), .clr_udf(clr_udf)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      ch_status_t st;
      txbuf_chan #(.DEPTH(DEPTH), .DATA_W(DATA_W), .THR_W(THR_W),
                   .READY_LAT(READY_LAT)) u_chan (
        .clk(clk), .rst(rst), .en_i(en_q[i]), .thr_i(thr_q),
        .s_valid_i(s_valid[i]), .s_data_i(s_data[i*DATA_W +: DATA_W]),
        .s_ready_o(s_ready[i]), .rd_en_i(rd_en[i]),
        .rd_data_o(rd_data[i*DATA_W +: DATA_W]),
        .clr_ovf_i(clr_ovf[i]), .clr_udf_i(clr_udf[i]), .status_o(st)
      );
      assign status[i*STATUS_W +: STATUS_W] = st;
    end
  endgenerate
endmodule

// File: tb/txbuf_bank_bench.sv
module txbuf_bank_bench;
  localparam int NCH = 4;
  localparam int DW = 32;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [NCH-1:0] s_valid = '0;
  logic [NCH*DW-1:0] s_data = '0;
  logic [NCH-1:0] rd_en = '0;
  logic [NCH-1:0] s_ready, s_ready_l1;
  logic [NCH*DW-1:0] rd_data, rd_data_l1;
  logic [NCH*3-1:0] status, status_l1;

  int n_checks = 0;
  int n_fail = 0;

  int fill_m [NCH];
  bit en_m [NCH];
  bit ovf_m [NCH];
  bit udf_m [NCH];
  int thr_m = 0;
  logic [31:0] data_q [NCH][$];
  logic [31:0] exp_q [NCH][$];

  always #2.5 clk = ~clk;

  txbuf_bank #(.READY_LAT(0)) u_txbuf_bank (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .rd_en(rd_en),
    .rd_data(rd_data), .status(status));

  txbuf_bank #(.READY_LAT(1)) u_txbuf_bank_lat1 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready_l1), .rd_en(rd_en),
    .rd_data(rd_data_l1), .status(status_l1));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model_clear();
    thr_m = 0;
    for (int c = 0; c < NCH; c++) begin
      fill_m[c] = 0; en_m[c] = 0; ovf_m[c] = 0; udf_m[c] = 0;
      data_q[c].delete(); exp_q[c].delete();
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    cyc();
    cfg_wr = 1'b0;
    if (a == 2'd0) thr_m = int'(d[4:0]);
    for (int c = 0; c < NCH; c++) begin
      if (a == 2'd1) begin
        en_m[c] = d[c];
        if (!d[c]) begin fill_m[c] = 0; data_q[c].delete(); end
      end
      if (a == 2'd2) begin
        if (d[c]) ovf_m[c] = 0;
        if (d[NCH+c]) udf_m[c] = 0;
      end
    end
  endtask

  // Driver: one cycle on one channel, optional write and read.
  task automatic xfer(input int ch, input bit w, input logic [31:0] d, input bit r);
    bit exp_rdy;
    int f0;
    exp_rdy = en_m[ch] && (fill_m[ch] < thr_m);
    check(s_ready[ch] == exp_rdy, "R1 ready", 32'(s_ready[ch]), 32'(exp_rdy));
    f0 = fill_m[ch];
    s_valid[ch] = w;
    s_data[ch*DW +: DW] = d;
    rd_en[ch] = r;
    if (r) begin
      if (en_m[ch] && f0 > 0) begin
        exp_q[ch].push_back(data_q[ch].pop_front());
        fill_m[ch]--;
      end else begin
        exp_q[ch].push_back(32'h0);
        if (en_m[ch]) udf_m[ch] = 1;
      end
    end
    if (w && exp_rdy) begin
      if (f0 < DEPTH) begin
        data_q[ch].push_back(d);
        fill_m[ch]++;
      end else ovf_m[ch] = 1;
    end
    cyc();
    s_valid[ch] = 1'b0;
    rd_en[ch] = 1'b0;
  endtask

  task automatic chk_status(input int ch, input string tag);
    logic [2:0] e;
    e = {ovf_m[ch], udf_m[ch], en_m[ch]};
    check(status[ch*3 +: 3] == e, tag, 32'(status[ch*3 +: 3]), 32'(e));
  endtask

  // Monitor: compares drained samples against the scoreboard.
  always @(posedge clk) begin
    logic [NCH-1:0] iss;
    iss = rd_en;
    #1;
    for (int c = 0; c < NCH; c++) begin
      if (iss[c] && exp_q[c].size() > 0) begin
        logic [31:0] e;
        e = exp_q[c].pop_front();
        check(rd_data[c*DW +: DW] == e, "R2/R4/R6 rd_data", rd_data[c*DW +: DW], e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    model_clear();
    @(negedge clk); cyc(); cyc();
    rst = 1'b0;
    cyc();
    // R9 reset state
    check(s_ready == '0, "R9 ready", 32'(s_ready), 32'h0);
    check(status == '0, "R9 status", 32'(status), 32'h0);
    check(rd_data[31:0] == '0, "R9 rd_data", rd_data[31:0], 32'h0);

    cfg_write(2'd0, 32'd4);
    cfg_write(2'd1, 32'hF);
    for (int c = 0; c < NCH; c++) chk_status(c, "R8 enable bit");

    // R1/R2: fill ch0 to threshold, ch1 stays ready
    for (int k = 0; k < 5; k++) xfer(0, 1'b1, 32'h1000 + 32'(k), 1'b0);
    check(s_ready[1] == 1'b1, "R1 per-channel", 32'(s_ready[1]), 32'h1);
    check(s_ready[0] == 1'b0, "R1 at threshold", 32'(s_ready[0]), 32'h0);
    // R4 ordered drain, R6 empty read
    for (int k = 0; k < 5; k++) xfer(0, 1'b0, 32'h0, 1'b1);
    chk_status(0, "R6 underflow");
    cyc(); cyc();
    chk_status(0, "R7 sticky");
    cfg_write(2'd2, 32'h1 << NCH);
    chk_status(0, "R7 clear");

    // R4 simultaneous read and write on ch3
    xfer(3, 1'b1, 32'hAAAA0001, 1'b0);
    xfer(3, 1'b1, 32'hAAAA0002, 1'b1);
    xfer(3, 1'b0, 32'h0, 1'b1);
    chk_status(3, "R4 status");

    // R5 overflow with threshold above depth
    cfg_write(2'd0, 32'd31);
    for (int k = 0; k < DEPTH + 1; k++) xfer(2, 1'b1, 32'h2000 + 32'(k), 1'b0);
    chk_status(2, "R5 overflow");
    for (int k = 0; k < DEPTH + 1; k++) xfer(2, 1'b0, 32'h0, 1'b1);
    chk_status(2, "R5 discard then underflow");
    cfg_write(2'd2, 32'h44);
    chk_status(2, "R7 clear both");

    // R8 disable flushes and ignores
    cfg_write(2'd0, 32'd4);
    xfer(1, 1'b1, 32'h3001, 1'b0);
    xfer(1, 1'b1, 32'h3002, 1'b0);
    cfg_write(2'd1, 32'hD);
    chk_status(1, "R8 disabled");
    xfer(1, 1'b1, 32'h3003, 1'b1);
    chk_status(1, "R8 ignored read");
    cfg_write(2'd1, 32'hF);
    xfer(1, 1'b0, 32'h0, 1'b1);
    chk_status(1, "R8 flushed");
    cyc();

    // R3 latency-one instance
    rst = 1'b1; cyc(); cyc(); rst = 1'b0;
    model_clear();
    cyc();
    cfg_write(2'd0, 32'd2);
    cfg_write(2'd1, 32'h1);
    check(s_ready_l1[0] == 1'b1, "R3 ready raised", 32'(s_ready_l1[0]), 32'h1);
    s_valid[0] = 1'b1; s_data[31:0] = 32'hA1A1A1A1;
    cyc();
    s_data[31:0] = 32'hB2B2B2B2;
    cyc();
    s_valid[0] = 1'b0;
    rd_en[0] = 1'b1; cyc(); rd_en[0] = 1'b0;
    check(rd_data_l1[31:0] == 32'hB2B2B2B2, "R3 stored next cycle", rd_data_l1[31:0], 32'hB2B2B2B2);
    rd_en[0] = 1'b1; cyc(); rd_en[0] = 1'b0;
    check(rd_data_l1[31:0] == 32'h0, "R3 early beat dropped", rd_data_l1[31:0], 32'h0);
    check(status_l1[1] == 1'b1, "R3 underflow after drain", 32'(status_l1[1]), 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule